// File: doc/BRIEF.md
# Quarter-Multiplex LCD Waveform Sequencer

This block turns a 128-bit segment word into drive-level codes for a liquid-crystal panel. The panel has four common (backplane) electrodes and 32 segment (frontplane) electrodes and uses 1/4 duty with 1/3 bias. The sequencer runs from a clock-enable pulse at oscillator rate. It steps through four backplane slots in a repeating frame, and each slot is split into two equal half-periods. Every electrode gets a 2-bit level code, and an external analog stage turns that code into one of four voltages.

Within a slot, the active backplane swings between the two outer levels and the idle backplanes swing between the two inner levels. Each frontplane takes the bit that belongs to the active backplane. Its polarity is arranged so that every segment sees zero average DC across the two half-periods. The segment word is copied into a shadow register only at the frame boundary, so a frame never shows a mix of old and new data. Each backplane level change also opens a short high-current window for an external driver.

Top module: `lcdq_seq`

## Requirements
- R1: After reset the shadow word is all zeros, the sequence sits in slot 0, half-period 0, and `hi_drive` is low. In that state backplane 0 is at code 11, the other backplanes are at 01, and every frontplane is at 10.
- R2: Position advances only on clock edges where `osc_tick` is high. A half-period lasts HALF_TICKS ticks and a frame lasts 2·N_BP·HALF_TICKS ticks, which is 1000 with the defaults.
- R3: Slots run 0,1,…,N_BP-1 and then repeat. Exactly one backplane is active per slot, and it is the one whose index equals the slot.
- R4: Level codes are 00 = 0 V, 01 = 1/3, 10 = 2/3 and 11 = full. The active backplane drives 11 in half 0 and 00 in half 1. An idle backplane drives 01 in half 0 and 10 in half 1.
- R5: Frontplane j uses bit `slot*N_FP + j` of the shadow word. A 1 drives 00 in half 0 and 11 in half 1. A 0 drives 10 in half 0 and 01 in half 1.
- R6: The shadow word loads `seg_word` only on the tick that ends the last half-period of the last slot. Changes to `seg_word` at any other time have no effect on the outputs.
- R7: `hi_drive` goes high on the edge where a half-period boundary is crossed. It stays high for exactly HI_TICKS ticks and is low at all other times.
- R8: Over each slot, the backplane code minus the frontplane code sums to zero for every segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | Oscillator-rate enable, one clock wide |
| seg_word | input | N_BP*N_FP | Latched segment data, block per backplane |
| bp_lvl | output | 2*N_BP | Backplane level codes, two bits per backplane |
| fp_lvl | output | 2*N_FP | Frontplane level codes, two bits per frontplane |
| hi_drive | output | 1 | High-current window after each backplane change |

## Verification
The bench sweeps several whole frames with a small half-period. It uses an irregular tick pattern that mixes back-to-back ticks with gaps, so a design that advanced on clock edges instead of ticks would drift out of step at once. The segment word carries junk all frame long and holds a valid pattern only on the wrap tick. A design that sampled it late, early or continuously would show the junk bits on the frontplanes. The high-current window is compared every cycle against the tick count since the last half boundary. This catches an off-by-one window length or a window left open after reset. Each frame uses its own data pattern, so a wrong bit-to-frontplane mapping or a swapped half-period polarity shows up as a mismatched code.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;

    typedef enum logic [1:0] {
        LVL_ZERO     = 2'b00,
        LVL_THIRD    = 2'b01,
        LVL_TWOTHIRD = 2'b10,
        LVL_FULL     = 2'b11
    } lvl_e;

    function automatic lvl_e bp_code(input logic active, input logic half);
        if (active) return half ? LVL_ZERO : LVL_FULL;
        else        return half ? LVL_TWOTHIRD : LVL_THIRD;
    endfunction

    function automatic lvl_e fp_code(input logic on, input logic half);
        if (on) return half ? LVL_FULL : LVL_ZERO;
        else    return half ? LVL_THIRD : LVL_TWOTHIRD;
    endfunction

endpackage

// File: rtl/lcdq_timebase.sv
module lcdq_timebase #(
    parameter int N_BP       = 4,
    parameter int HALF_TICKS = 125,
    localparam int SLOT_W    = (N_BP > 1) ? $clog2(N_BP) : 1,
    localparam int TICK_W    = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    output logic [SLOT_W-1:0] slot,
    output logic              half,
    output logic              step,
    output logic              frame_wrap
);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(HALF_TICKS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_BP - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic              half;
        logic [SLOT_W-1:0] slot;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      step_c, wrap_c;

    always_comb begin
        st_d   = st_q;
        step_c = osc_tick && (st_q.tick == TICK_LAST);
        wrap_c = step_c && st_q.half && (st_q.slot == SLOT_LAST);
        if (osc_tick) begin
            if (step_c) begin
                st_d.tick = '0;
                st_d.half = ~st_q.half;
                if (st_q.half) begin
                    st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + 1'b1;
                end
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot       = st_q.slot;
    assign half       = st_q.half;
    assign step       = step_c;
    assign frame_wrap = wrap_c;

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> ($stable(st_q.slot) && $stable(st_q.half) && $stable(st_q.tick)));

    assert_half_flips_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (st_q.half != $past(st_q.half)));

    assert_slot_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.half && st_q.slot != SLOT_LAST) |=> (st_q.slot == $past(st_q.slot) + 1'b1));

    assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (st_q.slot == '0 && !st_q.half));

endmodule

// File: rtl/lcdq_level_gen.sv
module lcdq_level_gen
    import lcdq_pkg::*;
#(
    parameter int N_BP    = 4,
    parameter int N_FP    = 32,
    localparam int SLOT_W = (N_BP > 1) ? $clog2(N_BP) : 1,
    localparam int WORD_W = N_BP * N_FP
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic               half,
    input  logic [WORD_W-1:0]  shadow,
    output logic [2*N_BP-1:0]  bp_lvl,
    output logic [2*N_FP-1:0]  fp_lvl
);
    logic [N_FP-1:0] block;

    always_comb begin
        block = '0;
        for (int b = 0; b < N_BP; b++) begin
            if (slot == SLOT_W'(b)) block = shadow[b*N_FP +: N_FP];
        end
    end

    for (genvar gb = 0; gb < N_BP; gb++) begin : g_bp
        assign bp_lvl[2*gb +: 2] = bp_code(slot == SLOT_W'(gb), half);
    end

    for (genvar gf = 0; gf < N_FP; gf++) begin : g_fp
        assign fp_lvl[2*gf +: 2] = fp_code(block[gf], half);
    end

endmodule

// File: rtl/lcdq_drive_timer.sv
module lcdq_drive_timer #(
    parameter int HI_TICKS = 4,
    localparam int HI_W    = $clog2(HI_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic step,
    output logic hi_drive
);
    logic [HI_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step)                         cnt_d = HI_W'(HI_TICKS);
        else if (osc_tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hi_drive = (cnt_q != '0);

    assert_hi_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> hi_drive);

    assert_hi_ends_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_drive && !osc_tick) |=> hi_drive);

    assert_hi_rises_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_drive && !step) |=> !hi_drive);

endmodule

// File: rtl/lcdq_seq.sv
module lcdq_seq
    import lcdq_pkg::*;
#(
    parameter int N_BP       = 4,
    parameter int N_FP       = 32,
    parameter int HALF_TICKS = 125,
    parameter int HI_TICKS   = 4,
    localparam int SLOT_W    = (N_BP > 1) ? $clog2(N_BP) : 1,
    localparam int WORD_W    = N_BP * N_FP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [WORD_W-1:0] seg_word,
    output logic [2*N_BP-1:0] bp_lvl,
    output logic [2*N_FP-1:0] fp_lvl,
    output logic              hi_drive
);
    logic [SLOT_W-1:0] slot;
    logic              half, step, frame_wrap;
    logic [WORD_W-1:0] shadow_d, shadow_q;

    lcdq_timebase #(.N_BP(N_BP), .HALF_TICKS(HALF_TICKS)) i_timebase (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .slot(slot), .half(half), .step(step), .frame_wrap(frame_wrap)
    );

    always_comb begin
        shadow_d = shadow_q;
        if (frame_wrap) shadow_d = seg_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
    end

    lcdq_level_gen #(.N_BP(N_BP), .N_FP(N_FP)) i_level_gen (
        .slot(slot), .half(half), .shadow(shadow_q),
        .bp_lvl(bp_lvl), .fp_lvl(fp_lvl)
    );

    lcdq_drive_timer #(.HI_TICKS(HI_TICKS)) i_drive_timer (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .step(step), .hi_drive(hi_drive)
    );

    logic [$clog2(N_BP+1)-1:0] outer_cnt;
    always_comb begin
        outer_cnt = '0;
        for (int b = 0; b < N_BP; b++) begin
            if (bp_lvl[2*b +: 2] == LVL_ZERO || bp_lvl[2*b +: 2] == LVL_FULL)
                outer_cnt = outer_cnt + 1'b1;
        end
    end

    assert_one_active_bp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        outer_cnt == 1);

    assert_shadow_only_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(shadow_q));

    assert_bp_swing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !half) |=> (bp_lvl != $past(bp_lvl)));

    assert_zero_dc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !half) |=> (fp_lvl == ~$past(fp_lvl)));

endmodule

// File: tb/test_lcdq_seq.sv
module test_lcdq_seq;
    localparam int NB = 4;
    localparam int NF = 32;
    localparam int H  = 5;
    localparam int HI = 2;
    localparam int FRAME = 2 * NB * H;
    localparam int W = NB * NF;

    logic clk = 0, rst_n = 0, osc_tick = 0;
    logic [W-1:0]    seg_word = '0;
    logic [2*NB-1:0] bp_lvl;
    logic [2*NF-1:0] fp_lvl;
    logic            hi_drive;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcdq_seq #(.N_BP(NB), .N_FP(NF), .HALF_TICKS(H), .HI_TICKS(HI)) i_lcdq_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .seg_word(seg_word),
        .bp_lvl(bp_lvl), .fp_lvl(fp_lvl), .hi_drive(hi_drive)
    );

    function automatic logic [W-1:0] pat(input int f);
        logic [W-1:0] p;
        for (int k = 0; k < NB; k++) p[k*NF +: NF] = 32'h9E3779B9 * (f * 4 + k + 3);
        if (f == 1) p = '1;
        if (f == 2) p = {NB{32'hA5C3_0F96}};
        return p;
    endfunction

    function automatic logic [W-1:0] junk(input int t);
        return ~pat(t + 7);
    endfunction

    function automatic logic [W-1:0] exp_shadow(input int t);
        int f = t / FRAME;
        return (f == 0) ? '0 : pat(f);
    endfunction

    function automatic logic [2*NB-1:0] exp_bp(input int t);
        logic [2*NB-1:0] v;
        int hidx = t / H;
        int sl = (hidx / 2) % NB;
        int hf = hidx % 2;
        for (int b = 0; b < NB; b++)
            v[2*b +: 2] = (b == sl) ? (hf ? 2'b00 : 2'b11) : (hf ? 2'b10 : 2'b01);
        return v;
    endfunction

    function automatic logic [2*NF-1:0] exp_fp(input int t);
        logic [2*NF-1:0] v;
        logic [W-1:0] sh = exp_shadow(t);
        int hidx = t / H;
        int sl = (hidx / 2) % NB;
        int hf = hidx % 2;
        for (int j = 0; j < NF; j++)
            v[2*j +: 2] = sh[sl*NF + j] ? (hf ? 2'b11 : 2'b00) : (hf ? 2'b01 : 2'b10);
        return v;
    endfunction

    function automatic logic exp_hi(input int t);
        return (t >= H) && ((t % H) < HI);
    endfunction

    task automatic check_all(input int t, input string tag);
        checks++;
        if (bp_lvl !== exp_bp(t)) begin
            errors++;
            $display("FAIL %s R3/R4 t=%0d bp_lvl actual=%h expected=%h", tag, t, bp_lvl, exp_bp(t));
        end
        checks++;
        if (fp_lvl !== exp_fp(t)) begin
            errors++;
            $display("FAIL %s R5/R6 t=%0d fp_lvl actual=%h expected=%h", tag, t, fp_lvl, exp_fp(t));
        end
        checks++;
        if (hi_drive !== exp_hi(t)) begin
            errors++;
            $display("FAIL %s R7 t=%0d hi_drive actual=%b expected=%b", tag, t, hi_drive, exp_hi(t));
        end
    endtask

    initial begin
        int t = 0;
        seg_word = junk(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(0, "R1 reset");
        rst_n = 1;
        for (int cyc = 0; cyc < 1400; cyc++) begin
            logic tk;
            @(negedge clk);
            check_all(t, "R2 sweep");
            tk = ((cyc % 5) != 2) && ((cyc % 3) != 0);
            osc_tick = tk;
            if (tk && (t % FRAME) == FRAME - 1) seg_word = pat(t / FRAME + 1);
            else                                seg_word = junk(cyc);
            @(posedge clk);
            #1;
            if (tk) t++;
            if (t >= 5 * FRAME + 3) break;
        end
        osc_tick = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            seg_word = junk(k + 100);
            check_all(t, "R6 idle");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule